// File: doc/BRIEF.md
# Write-Only I2C Configuration Register Slave

This block is a bus target for a two-wire serial bus that only takes write transfers. It holds the configuration register file of a six-channel light driver. The bus clock and data lines are sampled by the system clock, which must run at least ten times faster than the bus clock. START and STOP conditions are recognised on the sampled lines. A transfer carries a device address byte, then a register index byte, then one or more data bytes. The block acknowledges each byte it accepts. The pad is modelled as an output enable that pulls the data line low.

Brightness values, channel enables and timing values are written first into staging copies. They reach the outputs only when the matching update command is written. A write to the restore register puts every register back to its power-on value. The mode and current registers take effect as soon as they are written. Two update commands produce one-cycle strobes, which the pattern logic downstream uses to restart its timing.

Top module: `i2cw_regs_top`

## Requirements
- R1: The block acknowledges an address byte only when it equals {5'b11001, strap[1:0], 1'b0}. A read request (last bit 1) or any other address is not acknowledged. After such a byte, no further byte is acknowledged or written until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits are taken MSB first on the SCL rising edge. A STOP in the middle of a byte discards that byte.
- R3: For each accepted byte, sda_oe turns on while SCL is low after the eighth bit and turns off after the falling edge of the ninth clock. It also turns off on a STOP.
- R4: After reset the outputs take these values: run_en=0, chan_en=6'b111111, cfg1, ramp_cfg and mark_cfg 0, slave_mode=0, cur_lvl=0, aud_gain=0, all durations and duties 0, and no strobe.
- R5: Register 00h bit 0 drives run_en. 0 means shut down and 1 means normal operation.
- R6: Registers 03h, 05h and 06h drive cfg1, ramp_cfg and mark_cfg directly. Register 04h drives slave_mode from bit 7, cur_lvl from bits 6:4 and aud_gain from bits 2:0. All of these take effect at once.
- R7: Duty registers 07h+k (k=0..5) and the enable register 01h are staged. In 01h, channels 0-2 are bits 2:0 and channels 3-5 are bits 6:4. Writing 0x00 to 10h copies the staged values to pwm_duty (channel k in bits 8k+7:8k) and to chan_en. It also pulses data_upd_stb for one cycle.
- R8: The duration registers are staged. They are 11h+k for t0_time, 1Ah+g for t13_time (g=0..1) and 1Dh+k for t4_time, with byte k at bits 8k+7:8k. Writing 0x00 to 26h makes all of them active and pulses time_upd_stb for one cycle.
- R9: Writing 0x00 to FFh returns every staged and active register to its R4 value.
- R10: A write of a value other than 0x00 to 10h, 26h or FFh has no effect. A write to an index not listed above is acknowledged and discarded.
- R11: After each data byte, the index increments by one (modulo 256) for the next byte of the same transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line (wired level) |
| strap | input | 2 | Address strap bits |
| sda_oe | output | 1 | Pull data line low when 1 |
| run_en | output | 1 | 1 = normal operation, 0 = shut down |
| chan_en | output | 6 | Active per-channel enables |
| cfg1 | output | 8 | Mode register 03h |
| slave_mode | output | 1 | 0 master, 1 slave |
| cur_lvl | output | 3 | Output current level select |
| aud_gain | output | 3 | Audio gain select |
| ramp_cfg | output | 8 | Ramp register 05h |
| mark_cfg | output | 8 | Mark register 06h |
| pwm_duty | output | 48 | Active duties, channel k at 8k+7:8k |
| t0_time | output | 48 | Active start delays per channel |
| t13_time | output | 16 | Active ramp/hold codes per group |
| t4_time | output | 48 | Active off times per channel |
| data_upd_stb | output | 1 | One-cycle pulse on duty/enable update |
| time_upd_stb | output | 1 | One-cycle pulse on duration update |

## Verification
If the bit counter or byte phase goes wrong, the acknowledge lands in the wrong bit slot or is missing. The master sees this within the same byte. A corrupted index shows up on the output bus the next time an update command is written. A staging register that leaks through can be seen at once, because an active output changes without its strobe. An address decode fault shows as a stray acknowledge, or as a write that lands after a refused address. The bench compares every output against its own model after each transfer.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam logic [4:0] ADDR_TOP = 5'b11001;

  localparam logic [7:0] IX_RUN  = 8'h00;
  localparam logic [7:0] IX_EN   = 8'h01;
  localparam logic [7:0] IX_CFG1 = 8'h03;
  localparam logic [7:0] IX_CFG2 = 8'h04;
  localparam logic [7:0] IX_RAMP = 8'h05;
  localparam logic [7:0] IX_MARK = 8'h06;
  localparam logic [7:0] IX_PWM0 = 8'h07;
  localparam logic [7:0] IX_DUPD = 8'h10;
  localparam logic [7:0] IX_T0   = 8'h11;
  localparam logic [7:0] IX_T13  = 8'h1A;
  localparam logic [7:0] IX_T4   = 8'h1D;
  localparam logic [7:0] IX_TUPD = 8'h26;
  localparam logic [7:0] IX_RST  = 8'hFF;

  typedef enum logic [1:0] {L_IDLE, L_RX, L_ACK, L_SKIP} link_st_t;
  typedef enum logic [1:0] {B_ADDR, B_IDX, B_DATA} byte_ph_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh_q, sda_sh_q;
  logic              scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_p_q  <= 1'b1;
      sda_p_q  <= 1'b1;
    end else begin
      scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_in};
      sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_in};
      scl_p_q  <= scl_sh_q[STAGES-1];
      sda_p_q  <= sda_sh_q[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh_q[STAGES-1];
  assign sda_lvl   = sda_sh_q[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_p_q;
  assign scl_fall  = ~scl_lvl & scl_p_q;
  assign start_evt = scl_lvl & scl_p_q & sda_p_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_p_q & ~sda_p_q & sda_lvl;
endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
  import i2cw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data
);
  localparam logic [3:0] FULL = 4'd8;

  link_st_t   st_q, st_n;
  byte_ph_t   ph_q, ph_n;
  logic [3:0] bcnt_q, bcnt_n;
  logic [7:0] sh_q, sh_n;
  logic [7:0] idx_q, idx_n;
  logic [7:0] dat_q, dat_n;
  logic       oe_q, oe_n;
  logic       stb_q, stb_n;
  logic [7:0] my_addr;

  assign my_addr = {ADDR_TOP, strap, 1'b0};

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    bcnt_n = bcnt_q;
    sh_n   = sh_q;
    idx_n  = idx_q;
    dat_n  = dat_q;
    oe_n   = oe_q;
    stb_n  = 1'b0;
    if (stop_evt) begin
      st_n = L_IDLE;
      oe_n = 1'b0;
    end else if (start_evt) begin
      st_n   = L_RX;
      ph_n   = B_ADDR;
      bcnt_n = '0;
      oe_n   = 1'b0;
    end else begin
      case (st_q)
        L_RX: begin
          if (scl_rise && bcnt_q != FULL) begin
            sh_n   = {sh_q[6:0], sda_lvl};
            bcnt_n = bcnt_q + 4'd1;
          end else if (scl_fall && bcnt_q == FULL) begin
            st_n = L_ACK;
            oe_n = 1'b1;
            case (ph_q)
              B_ADDR: if (sh_q != my_addr) begin
                st_n = L_SKIP;
                oe_n = 1'b0;
              end
              B_IDX:  idx_n = sh_q;
              default: begin
                stb_n = 1'b1;
                dat_n = sh_q;
              end
            endcase
          end
        end
        L_ACK: begin
          if (scl_fall) begin
            oe_n   = 1'b0;
            st_n   = L_RX;
            bcnt_n = '0;
            case (ph_q)
              B_ADDR:  ph_n = B_IDX;
              B_IDX:   ph_n = B_DATA;
              default: idx_n = idx_q + 8'd1;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= L_IDLE;
      ph_q   <= B_ADDR;
      bcnt_q <= '0;
      sh_q   <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
      oe_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      bcnt_q <= bcnt_n;
      sh_q   <= sh_n;
      idx_q  <= idx_n;
      dat_q  <= dat_n;
      oe_q   <= oe_n;
      stb_q  <= stb_n;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_stb  = stb_q;
  assign wr_idx  = idx_q;
  assign wr_data = dat_q;
endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile
  import i2cw_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int NGRP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [7:0]           wr_idx,
  input  logic [7:0]           wr_data,
  output logic                 run_en,
  output logic [NCH-1:0]       chan_en,
  output logic [7:0]           cfg1,
  output logic                 slave_mode,
  output logic [2:0]           cur_lvl,
  output logic [2:0]           aud_gain,
  output logic [7:0]           ramp_cfg,
  output logic [7:0]           mark_cfg,
  output logic [NCH*8-1:0]     pwm_duty,
  output logic [NCH*8-1:0]     t0_time,
  output logic [NGRP*8-1:0]    t13_time,
  output logic [NCH*8-1:0]     t4_time,
  output logic                 data_upd_stb,
  output logic                 time_upd_stb,
  output logic                 dflt_stb
);
  typedef logic [NCH-1:0][7:0]  chan_arr_t;
  typedef logic [NGRP-1:0][7:0] grp_arr_t;

  logic            run_q, run_n;
  logic [NCH-1:0]  en_stg_q, en_stg_n, en_act_q, en_act_n, en_wr;
  logic [7:0]      cfg1_q, cfg1_n, ramp_q, ramp_n, mark_q, mark_n;
  logic [6:0]      cfg2_q, cfg2_n;
  chan_arr_t       pwm_stg_q, pwm_stg_n, pwm_act_q, pwm_act_n;
  chan_arr_t       t0_stg_q, t0_stg_n, t0_act_q, t0_act_n;
  chan_arr_t       t4_stg_q, t4_stg_n, t4_act_q, t4_act_n;
  grp_arr_t        t13_stg_q, t13_stg_n, t13_act_q, t13_act_n;
  logic            dstb_q, tstb_q, rstb_q;
  logic            cmd_data, cmd_time, cmd_rst;

  // enable bit of channel k sits in nibble k/3, position k%3
  for (genvar k = 0; k < NCH; k++) begin : g_enmap
    assign en_wr[k] = wr_data[(k/3)*4 + (k%3)];
  end

  assign cmd_data = wr_stb && wr_idx == IX_DUPD && wr_data == 8'h00;
  assign cmd_time = wr_stb && wr_idx == IX_TUPD && wr_data == 8'h00;
  assign cmd_rst  = wr_stb && wr_idx == IX_RST  && wr_data == 8'h00;

  always_comb begin
    run_n     = run_q;
    en_stg_n  = en_stg_q;
    en_act_n  = en_act_q;
    cfg1_n    = cfg1_q;
    cfg2_n    = cfg2_q;
    ramp_n    = ramp_q;
    mark_n    = mark_q;
    pwm_stg_n = pwm_stg_q;
    pwm_act_n = pwm_act_q;
    t0_stg_n  = t0_stg_q;
    t0_act_n  = t0_act_q;
    t13_stg_n = t13_stg_q;
    t13_act_n = t13_act_q;
    t4_stg_n  = t4_stg_q;
    t4_act_n  = t4_act_q;
    if (wr_stb) begin
      if (wr_idx == IX_RUN)  run_n    = wr_data[0];
      if (wr_idx == IX_EN)   en_stg_n = en_wr;
      if (wr_idx == IX_CFG1) cfg1_n   = wr_data;
      if (wr_idx == IX_CFG2) cfg2_n   = {wr_data[7:4], wr_data[2:0]};
      if (wr_idx == IX_RAMP) ramp_n   = wr_data;
      if (wr_idx == IX_MARK) mark_n   = wr_data;
      for (int k = 0; k < NCH; k++) begin
        if (wr_idx == IX_PWM0 + 8'(k)) pwm_stg_n[k] = wr_data;
        if (wr_idx == IX_T0 + 8'(k))   t0_stg_n[k]  = wr_data;
        if (wr_idx == IX_T4 + 8'(k))   t4_stg_n[k]  = wr_data;
      end
      for (int g = 0; g < NGRP; g++) begin
        if (wr_idx == IX_T13 + 8'(g)) t13_stg_n[g] = wr_data;
      end
    end
    if (cmd_data) begin
      en_act_n  = en_stg_q;
      pwm_act_n = pwm_stg_q;
    end
    if (cmd_time) begin
      t0_act_n  = t0_stg_q;
      t13_act_n = t13_stg_q;
      t4_act_n  = t4_stg_q;
    end
    if (cmd_rst) begin
      run_n     = 1'b0;
      en_stg_n  = '1;
      en_act_n  = '1;
      cfg1_n    = '0;
      cfg2_n    = '0;
      ramp_n    = '0;
      mark_n    = '0;
      pwm_stg_n = '0;
      pwm_act_n = '0;
      t0_stg_n  = '0;
      t0_act_n  = '0;
      t13_stg_n = '0;
      t13_act_n = '0;
      t4_stg_n  = '0;
      t4_act_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      en_stg_q  <= '1;
      en_act_q  <= '1;
      cfg1_q    <= '0;
      cfg2_q    <= '0;
      ramp_q    <= '0;
      mark_q    <= '0;
      pwm_stg_q <= '0;
      pwm_act_q <= '0;
      t0_stg_q  <= '0;
      t0_act_q  <= '0;
      t13_stg_q <= '0;
      t13_act_q <= '0;
      t4_stg_q  <= '0;
      t4_act_q  <= '0;
      dstb_q    <= 1'b0;
      tstb_q    <= 1'b0;
      rstb_q    <= 1'b0;
    end else begin
      run_q     <= run_n;
      en_stg_q  <= en_stg_n;
      en_act_q  <= en_act_n;
      cfg1_q    <= cfg1_n;
      cfg2_q    <= cfg2_n;
      ramp_q    <= ramp_n;
      mark_q    <= mark_n;
      pwm_stg_q <= pwm_stg_n;
      pwm_act_q <= pwm_act_n;
      t0_stg_q  <= t0_stg_n;
      t0_act_q  <= t0_act_n;
      t13_stg_q <= t13_stg_n;
      t13_act_q <= t13_act_n;
      t4_stg_q  <= t4_stg_n;
      t4_act_q  <= t4_act_n;
      dstb_q    <= cmd_data;
      tstb_q    <= cmd_time;
      rstb_q    <= cmd_rst;
    end
  end

  assign run_en       = run_q;
  assign chan_en      = en_act_q;
  assign cfg1         = cfg1_q;
  assign slave_mode   = cfg2_q[6];
  assign cur_lvl      = cfg2_q[5:3];
  assign aud_gain     = cfg2_q[2:0];
  assign ramp_cfg     = ramp_q;
  assign mark_cfg     = mark_q;
  assign pwm_duty     = pwm_act_q;
  assign t0_time      = t0_act_q;
  assign t13_time     = t13_act_q;
  assign t4_time      = t4_act_q;
  assign data_upd_stb = dstb_q;
  assign time_upd_stb = tstb_q;
  assign dflt_stb     = rstb_q;
endmodule

// File: rtl/i2cw_regs_top.sv
module i2cw_regs_top #(
  parameter int NCH     = 6,
  parameter int NGRP    = 2,
  parameter int SYNC_FF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [1:0]        strap,
  output logic              sda_oe,
  output logic              run_en,
  output logic [NCH-1:0]    chan_en,
  output logic [7:0]        cfg1,
  output logic              slave_mode,
  output logic [2:0]        cur_lvl,
  output logic [2:0]        aud_gain,
  output logic [7:0]        ramp_cfg,
  output logic [7:0]        mark_cfg,
  output logic [NCH*8-1:0]  pwm_duty,
  output logic [NCH*8-1:0]  t0_time,
  output logic [NGRP*8-1:0] t13_time,
  output logic [NCH*8-1:0]  t4_time,
  output logic              data_upd_stb,
  output logic              time_upd_stb
);
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_stb, dflt_stb;
  logic [7:0] wr_idx, wr_data;

  i2cw_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cw_link u_link (
    .clk(clk), .rst_n(rst_n), .strap(strap), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  i2cw_regfile #(.NCH(NCH), .NGRP(NGRP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .run_en(run_en), .chan_en(chan_en), .cfg1(cfg1),
    .slave_mode(slave_mode), .cur_lvl(cur_lvl), .aud_gain(aud_gain),
    .ramp_cfg(ramp_cfg), .mark_cfg(mark_cfg), .pwm_duty(pwm_duty),
    .t0_time(t0_time), .t13_time(t13_time), .t4_time(t4_time),
    .data_upd_stb(data_upd_stb), .time_upd_stb(time_upd_stb),
    .dflt_stb(dflt_stb)
  );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
  parameter int NCH  = 6,
  parameter int NGRP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic [NCH-1:0]    chan_en,
  input logic [NCH*8-1:0]  pwm_duty,
  input logic [NCH*8-1:0]  t0_time,
  input logic [NGRP*8-1:0] t13_time,
  input logic [NCH*8-1:0]  t4_time,
  input logic              data_upd_stb,
  input logic              time_upd_stb,
  input logic              dflt_stb
);
  // R3
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_duty) |-> (data_upd_stb || dflt_stb));

  // R7
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> (data_upd_stb || dflt_stb));

  // R8
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({t0_time, t13_time, t4_time}) |-> (time_upd_stb || dflt_stb));

  // R7
  dstb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_upd_stb |=> !data_upd_stb);

  // R8
  tstb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_upd_stb |=> !time_upd_stb);

  // R10
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_upd_stb, time_upd_stb, dflt_stb}));
endmodule

bind i2cw_regs_top i2cw_checker #(.NCH(NCH), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .stop_evt(stop_evt),
  .sda_oe(sda_oe), .chan_en(chan_en), .pwm_duty(pwm_duty),
  .t0_time(t0_time), .t13_time(t13_time), .t4_time(t4_time),
  .data_upd_stb(data_upd_stb), .time_upd_stb(time_upd_stb),
  .dflt_stb(dflt_stb)
);

// File: tb/tb_i2cw_regs_top.sv
`timescale 1ns/1ps
module tb_i2cw_regs_top;
  localparam int Q = 10;

  logic clk, rst_n, scl_m, sda_m;
  logic [1:0] strap;
  logic sda_oe, run_en, slave_mode, data_upd_stb, time_upd_stb;
  logic [5:0] chan_en;
  logic [7:0] cfg1, ramp_cfg, mark_cfg;
  logic [2:0] cur_lvl, aud_gain;
  logic [47:0] pwm_duty, t0_time, t4_time;
  logic [15:0] t13_time;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  i2cw_regs_top dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .strap(strap), .sda_oe(sda_oe), .run_en(run_en), .chan_en(chan_en),
    .cfg1(cfg1), .slave_mode(slave_mode), .cur_lvl(cur_lvl),
    .aud_gain(aud_gain), .ramp_cfg(ramp_cfg), .mark_cfg(mark_cfg),
    .pwm_duty(pwm_duty), .t0_time(t0_time), .t13_time(t13_time),
    .t4_time(t4_time), .data_upd_stb(data_upd_stb),
    .time_upd_stb(time_upd_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int d_hi = 0, t_hi = 0, e_d = 0, e_t = 0;

  always @(posedge clk) begin
    if (data_upd_stb) d_hi++;
    if (time_upd_stb) t_hi++;
  end

  // bench model
  logic       m_run;
  logic [5:0] m_en_stg, m_en_act;
  logic [7:0] m_cfg1, m_cfg2, m_ramp, m_mark;
  logic [5:0][7:0] m_pwm_stg, m_pwm_act, m_t0_stg, m_t0_act, m_t4_stg, m_t4_act;
  logic [1:0][7:0] m_t13_stg, m_t13_act;
  logic [7:0] buf_d [8];

  function automatic logic [5:0] en_of(input logic [7:0] d);
    return {d[6:4], d[2:0]};
  endfunction

  function automatic logic [7:0] my_addr(input logic [1:0] s, input bit rd);
    return {5'b11001, s, rd};
  endfunction

  task automatic model_reset();
    m_run = 0; m_en_stg = '1; m_en_act = '1;
    m_cfg1 = 0; m_cfg2 = 0; m_ramp = 0; m_mark = 0;
    m_pwm_stg = '0; m_pwm_act = '0; m_t0_stg = '0; m_t0_act = '0;
    m_t4_stg = '0; m_t4_act = '0; m_t13_stg = '0; m_t13_act = '0;
  endtask

  task automatic model_wr(input logic [7:0] ix, input logic [7:0] d);
    if (ix == 8'h00) m_run = d[0];
    if (ix == 8'h01) m_en_stg = en_of(d);
    if (ix == 8'h03) m_cfg1 = d;
    if (ix == 8'h04) m_cfg2 = {d[7:4], 1'b0, d[2:0]};
    if (ix == 8'h05) m_ramp = d;
    if (ix == 8'h06) m_mark = d;
    if (ix >= 8'h07 && ix <= 8'h0C) m_pwm_stg[ix - 8'h07] = d;
    if (ix >= 8'h11 && ix <= 8'h16) m_t0_stg[ix - 8'h11] = d;
    if (ix >= 8'h1A && ix <= 8'h1B) m_t13_stg[ix - 8'h1A] = d;
    if (ix >= 8'h1D && ix <= 8'h22) m_t4_stg[ix - 8'h1D] = d;
    if (ix == 8'h10 && d == 0) begin
      m_en_act = m_en_stg; m_pwm_act = m_pwm_stg; e_d++;
    end
    if (ix == 8'h26 && d == 0) begin
      m_t0_act = m_t0_stg; m_t13_act = m_t13_stg; m_t4_act = m_t4_stg; e_t++;
    end
    if (ix == 8'hFF && d == 0) model_reset();
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string ctx);
    chk(run_en == m_run, "R5", {ctx, " run_en"}, 64'(run_en), 64'(m_run));
    chk(chan_en == m_en_act, "R7", {ctx, " chan_en"}, 64'(chan_en), 64'(m_en_act));
    chk(cfg1 == m_cfg1 && ramp_cfg == m_ramp && mark_cfg == m_mark, "R6",
        {ctx, " cfg1/ramp/mark"}, {40'd0, cfg1, ramp_cfg, mark_cfg},
        {40'd0, m_cfg1, m_ramp, m_mark});
    chk({slave_mode, cur_lvl, aud_gain} == {m_cfg2[7:4], m_cfg2[2:0]}, "R6",
        {ctx, " cfg2 fields"}, 64'({slave_mode, cur_lvl, aud_gain}),
        64'({m_cfg2[7:4], m_cfg2[2:0]}));
    chk(pwm_duty == m_pwm_act, "R7", {ctx, " pwm_duty"}, 64'(pwm_duty), 64'(m_pwm_act));
    chk(t0_time == m_t0_act && t4_time == m_t4_act && t13_time == m_t13_act, "R8",
        {ctx, " durations"}, 64'(t0_time ^ t4_time ^ 48'(t13_time)),
        64'(m_t0_act ^ m_t4_act ^ 48'(m_t13_act)));
    chk(d_hi == e_d, "R7", {ctx, " data_upd_stb cycles"}, 64'(d_hi), 64'(e_d));
    chk(t_hi == e_t, "R8", {ctx, " time_upd_stb cycles"}, 64'(t_hi), 64'(e_t));
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; qwait(); scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait();
  endtask

  task automatic i2c_stop();
    sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait(); qwait();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; qwait(); scl_m = 1; qwait();
    ack = ~sda_line;
    qwait(); scl_m = 0; qwait();
  endtask

  task automatic xfer(input logic [7:0] addr, input logic [7:0] ix, input int n,
                      input bit exp_ack, input string req);
    bit a;
    i2c_start();
    send_byte(addr, a);
    chk(a == exp_ack, req, "address ack", 64'(a), 64'(exp_ack));
    send_byte(ix, a);
    chk(a == exp_ack, "R3", "index ack", 64'(a), 64'(exp_ack));
    for (int i = 0; i < n; i++) begin
      send_byte(buf_d[i], a);
      chk(a == exp_ack, "R3", "data ack", 64'(a), 64'(exp_ack));
      if (exp_ack) model_wr(ix + 8'(i), buf_d[i]);
    end
    i2c_stop();
    repeat (20) @(negedge clk);
  endtask

  task automatic wr1(input logic [7:0] ix, input logic [7:0] d);
    buf_d[0] = d;
    xfer(my_addr(strap, 0), ix, 1, 1, "R1");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    void'($urandom(32'd1234));
    scl_m = 1; sda_m = 1; strap = 2'b10; rst_n = 0;
    model_reset();
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R4 reset state
    chk(sda_oe == 0, "R4", "sda_oe after reset", 64'(sda_oe), 0);
    compare_all("R4 reset");

    // R5 run control
    wr1(8'h00, 8'h01);
    compare_all("R5 run on");

    // R6 and R11: auto-increment across 03h..06h
    buf_d[0] = 8'hA5; buf_d[1] = 8'hDB; buf_d[2] = 8'h3C; buf_d[3] = 8'h12;
    xfer(my_addr(strap, 0), 8'h03, 4, 1, "R11");
    compare_all("R6 R11 cfg burst");

    // R7 staged duties, burst of six
    for (int k = 0; k < 6; k++) buf_d[k] = 8'(8'h20 + 8'h17 * k);
    xfer(my_addr(strap, 0), 8'h07, 6, 1, "R11");
    compare_all("R7 staged only");
    wr1(8'h01, 8'h25);
    compare_all("R7 enable staged");
    wr1(8'h10, 8'h5A);
    compare_all("R10 nonzero data update");
    wr1(8'h10, 8'h00);
    compare_all("R7 data update");

    // R8 staged durations
    for (int k = 0; k < 6; k++) buf_d[k] = 8'(8'h31 + 8'h0B * k);
    xfer(my_addr(strap, 0), 8'h11, 6, 1, "R8");
    buf_d[0] = 8'h47; buf_d[1] = 8'h7A;
    xfer(my_addr(strap, 0), 8'h1A, 2, 1, "R8");
    for (int k = 0; k < 6; k++) buf_d[k] = 8'(8'hC3 - 8'h13 * k);
    xfer(my_addr(strap, 0), 8'h1D, 6, 1, "R8");
    compare_all("R8 staged only");
    wr1(8'h26, 8'h01);
    compare_all("R10 nonzero time update");
    wr1(8'h26, 8'h00);
    compare_all("R8 time update");

    // R1 wrong strap and read request are refused, rest ignored
    buf_d[0] = 8'h00;
    xfer(my_addr(2'b01, 0), 8'h03, 1, 0, "R1");
    buf_d[0] = 8'h00;
    xfer(my_addr(strap, 1), 8'hFF, 1, 0, "R1");
    compare_all("R1 refused");

    // R10 unlisted indices; R11 run from 0Ch into unlisted 0Dh
    wr1(8'h02, 8'hEE);
    buf_d[0] = 8'h99; buf_d[1] = 8'h88;
    xfer(my_addr(strap, 0), 8'h0C, 2, 1, "R10");
    wr1(8'h10, 8'h00);
    compare_all("R10 unlisted");

    // R2 STOP in the middle of a byte discards it
    i2c_start();
    send_byte(my_addr(strap, 0), a);
    send_byte(8'h07, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_stop();
    repeat (20) @(negedge clk);
    chk(sda_oe == 0, "R2", "sda_oe after stop", 64'(sda_oe), 0);
    wr1(8'h10, 8'h00);
    compare_all("R2 aborted byte");

    // random mix
    for (int it = 0; it < 30; it++) begin
      int n;
      logic [7:0] ix;
      n = 1 + int'($urandom % 3);
      if ($urandom % 8 == 0) ix = 8'hFF;
      else ix = 8'($urandom % 32'h28);
      for (int i = 0; i < n; i++)
        buf_d[i] = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      xfer(my_addr(strap, 0), ix, n, 1, "R11");
      compare_all("random");
    end

    // R9 restore
    wr1(8'h00, 8'h01);
    wr1(8'hFF, 8'h05);
    compare_all("R10 nonzero restore");
    wr1(8'hFF, 8'h00);
    compare_all("R9 restore");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule